// File: doc/BRIEF.md
# Host Reset Request Arbiter

This block watches three request lines that come from the application processor and decides what the processor is asking for. The lines are a warm-reset request (active high), a shutdown request (active low) and a watchdog indication (active low). A rising warm-reset request is a reboot. The block answers it with a system reset output that is driven low for a fixed number of clock cycles and then released high. A falling shutdown request is a power-off only when two conditions hold: no warm-reset request came before it, and the watchdog is not asserted. In that case the block sets a sticky shutdown flag for the power controller.

The processor often raises the warm-reset request just before it drops the shutdown request. A pending-reboot marker records that warm-reset request. The next shutdown-request edge consumes the marker, in either direction. When the watchdog is low, the shutdown edge belongs to a watchdog reset that the processor handles itself, so it is ignored. The power controller pulses a clear input once the system reaches full off, and that drops the flag.

All three request lines are asynchronous. Each passes through a synchroniser, and the block acts only on edges of the synchronised levels. The pulse length comes from the clock rate and a length in milliseconds.

Top module: `hostreq_reset_arbiter`

## Requirements
- R1: A change on a request input takes effect on the outputs at the third rising clock edge after it is sampled, and not at the second.
- R2: A rising edge of the warm-reset request drives `sys_rst_n_o` low for exactly CLK_KHZ*PULSE_MS clock cycles, after which it returns high.
- R3: A warm-reset rising edge that arrives while the reset pulse is active does not extend the pulse and does not start a second pulse.
- R4: A falling edge of the shutdown request sets `shutdown_o` when the watchdog line is high and no reboot is pending.
- R5: A warm-reset rising edge marks a reboot as pending. A later shutdown falling edge then leaves `shutdown_o` low.
- R6: A shutdown falling edge seen while the watchdog line is low leaves `shutdown_o` low.
- R7: Every shutdown-request edge, rising or falling, clears the pending reboot. This holds whether or not the edge latches the flag.
- R8: `shutdown_o` stays high until `flag_clear_i` is high at a clock edge, and it is low after that edge. When a qualifying shutdown edge and the clear fall on the same cycle, the flag is set.
- R9: A warm-reset rising edge and a shutdown falling edge in the same cycle count as a reboot. The reset pulse starts and `shutdown_o` stays low.
- R10: Under reset, `sys_rst_n_o` is high and `shutdown_o` is low. The synchronisers reset to the inactive input levels, so idle inputs produce no event after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| warm_req_i | input | 1 | Warm-reset request from the processor, active high, asynchronous |
| shut_req_n_i | input | 1 | Shutdown request from the processor, active low, asynchronous |
| wdog_n_i | input | 1 | Processor watchdog indication, active low, asynchronous |
| flag_clear_i | input | 1 | Synchronous clear of the shutdown flag |
| sys_rst_n_o | output | 1 | System reset output, active low, registered |
| shutdown_o | output | 1 | Sticky shutdown flag for the power controller, registered |

## Verification
A request input that changes at a falling clock edge passes through two synchroniser stages and one edge register. Its effect therefore appears at the third rising edge. The bench samples the outputs at the third falling edge after the drive and confirms at the second that nothing has moved yet. The flag clear is not synchronised, so its effect is due one edge later and is sampled at the next falling edge. The reset pulse is measured by counting the falling-edge samples at which `sys_rst_n_o` is low, starting at the drive. The count must equal the configured cycle count, and the first low sample must fall at the third sample.

// File: rtl/hra_pkg.sv
package hra_pkg;

  // Synchronised view of the three processor request lines.
  typedef struct packed {
    logic warm;    // warm-reset request, active high
    logic shut_n;  // shutdown request, active low
    logic wdog_n;  // watchdog indication, active low
  } req_t;

  localparam int REQ_W = $bits(req_t);

  // Inactive level of every request line; used as synchroniser reset value.
  localparam req_t REQ_IDLE = '{warm: 1'b0, shut_n: 1'b1, wdog_n: 1'b1};

endpackage

// File: rtl/hra_sync.sv
module hra_sync #(
  parameter int              WIDTH   = 3,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] chain_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [WIDTH-1:0] stage_in;
    if (g == 0) begin : g_first
      assign stage_in = d_i;
    end else begin : g_next
      assign stage_in = chain_q[g-1];
    end

    always_ff @(posedge clk) begin
      if (rst) chain_q[g] <= RST_VAL;
      else     chain_q[g] <= stage_in;
    end
  end

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/hra_edge.sv
module hra_edge
  import hra_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  req_t lvl_i,
  output logic warm_rise_o,
  output logic shut_evt_o,
  output logic shut_fall_o
);

  req_t prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= REQ_IDLE;
    else     prev_q <= lvl_i;
  end

  assign warm_rise_o = lvl_i.warm & ~prev_q.warm;
  assign shut_evt_o  = lvl_i.shut_n ^ prev_q.shut_n;
  assign shut_fall_o = ~lvl_i.shut_n & prev_q.shut_n;

endmodule

// File: rtl/hra_pulse.sv
module hra_pulse #(
  parameter int PULSE_CYCLES = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic rst_n_o
);

  localparam int CNT_W = $clog2(PULSE_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PULSE_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             low_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      low_q <= 1'b0;
    end else if (low_q) begin
      // Active pulse: new starts are ignored, the count only runs down.
      if (cnt_q == '0) low_q <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end else if (start_i) begin
      cnt_q <= CNT_LOAD;
      low_q <= 1'b1;
    end
  end

  assign rst_n_o = ~low_q;

  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    int'(cnt_q) < PULSE_CYCLES);

  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    (low_q && $past(low_q)) |-> cnt_q == $past(cnt_q) - 1'b1);

  // R3
  no_retrig_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(start_i) && $past(low_q) && $past(cnt_q) != '0) |-> (low_q && cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/hra_decide.sv
module hra_decide (
  input  logic clk,
  input  logic rst,
  input  logic warm_rise_i,
  input  logic shut_evt_i,
  input  logic shut_fall_i,
  input  logic wdog_n_i,
  input  logic clear_i,
  output logic shutdown_o
);

  logic want_q;
  logic shut_q;
  logic qualify;

  // A falling shutdown edge is a power-off only with the watchdog idle,
  // no earlier reboot request, and no reboot request in the same cycle.
  assign qualify = shut_fall_i & wdog_n_i & ~want_q & ~warm_rise_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      want_q <= 1'b0;
      shut_q <= 1'b0;
    end else begin
      if (shut_evt_i)       want_q <= 1'b0;
      else if (warm_rise_i) want_q <= 1'b1;

      if (qualify)      shut_q <= 1'b1;
      else if (clear_i) shut_q <= 1'b0;
    end
  end

  assign shutdown_o = shut_q;

  // R4
  set_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(shut_q) |-> $past(shut_fall_i && wdog_n_i));

  // R5
  pending_block_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(want_q) && $past(shut_evt_i) && !$past(shut_q)) |-> !shut_q);

  // R6
  wdog_block_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(!wdog_n_i) && !$past(shut_q)) |-> !shut_q);

  // R7
  want_clr_chk: assert property (@(posedge clk) disable iff (rst)
    $past(shut_evt_i) |-> !want_q);

  // R8
  flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(shut_q) && !$past(clear_i)) |-> shut_q);

endmodule

// File: rtl/hostreq_reset_arbiter.sv
module hostreq_reset_arbiter
  import hra_pkg::*;
#(
  parameter int CLK_KHZ     = 100000,
  parameter int PULSE_MS    = 30,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic warm_req_i,
  input  logic shut_req_n_i,
  input  logic wdog_n_i,
  input  logic flag_clear_i,
  output logic sys_rst_n_o,
  output logic shutdown_o
);

  localparam int PULSE_CYCLES = CLK_KHZ * PULSE_MS;

  req_t raw_req;
  req_t sync_req;
  logic warm_rise;
  logic shut_evt;
  logic shut_fall;

  assign raw_req = '{warm: warm_req_i, shut_n: shut_req_n_i, wdog_n: wdog_n_i};

  hra_sync #(
    .WIDTH  (REQ_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL(REQ_IDLE)
  ) u_sync (
    .clk(clk),
    .rst(rst),
    .d_i(raw_req),
    .q_o(sync_req)
  );

  hra_edge u_edge (
    .clk        (clk),
    .rst        (rst),
    .lvl_i      (sync_req),
    .warm_rise_o(warm_rise),
    .shut_evt_o (shut_evt),
    .shut_fall_o(shut_fall)
  );

  hra_pulse #(
    .PULSE_CYCLES(PULSE_CYCLES)
  ) u_pulse (
    .clk    (clk),
    .rst    (rst),
    .start_i(warm_rise),
    .rst_n_o(sys_rst_n_o)
  );

  hra_decide u_decide (
    .clk        (clk),
    .rst        (rst),
    .warm_rise_i(warm_rise),
    .shut_evt_i (shut_evt),
    .shut_fall_i(shut_fall),
    .wdog_n_i   (sync_req.wdog_n),
    .clear_i    (flag_clear_i),
    .shutdown_o (shutdown_o)
  );

  // R2
  pulse_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(sys_rst_n_o) |-> $past(warm_rise));

  // R9
  same_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(warm_rise) && $past(shut_fall) && !$past(shutdown_o)) |-> !shutdown_o);

endmodule

// File: tb/hostreq_reset_arbiter_tb.sv
module hostreq_reset_arbiter_tb;

  localparam int CLK_PERIOD = 10;
  localparam int P          = 12;  // CLK_KHZ=1, PULSE_MS=12

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic warm = 1'b0;
  logic shut_n = 1'b1;
  logic wdog_n = 1'b1;
  logic clr = 1'b0;
  logic sys_rst_n;
  logic sd;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hostreq_reset_arbiter #(
    .CLK_KHZ    (1),
    .PULSE_MS   (P),
    .SYNC_STAGES(2)
  ) u_dut (
    .clk         (clk),
    .rst         (rst),
    .warm_req_i  (warm),
    .shut_req_n_i(shut_n),
    .wdog_n_i    (wdog_n),
    .flag_clear_i(clr),
    .sys_rst_n_o (sys_rst_n),
    .shutdown_o  (sd)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic nwait(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_flag();
    clr = 1'b1;
    nwait(1);
    clr = 1'b0;
  endtask

  // Consume any pending reboot with two shutdown edges that cannot latch.
  task automatic flush();
    wdog_n = 1'b0; nwait(4);
    shut_n = 1'b0; nwait(4);
    chk("R6 flush fall with watchdog low", sd, 0);
    shut_n = 1'b1; nwait(4);
    wdog_n = 1'b1; nwait(4);
  endtask

  // Drive a warm request at sample 0, optionally retrigger, count low samples.
  task automatic pulse_run(input bit retrig, output int low_cnt, output int first_low);
    low_cnt = 0;
    first_low = -1;
    warm = 1'b1;
    for (int i = 0; i < P + 20; i++) begin
      if (!sys_rst_n) begin
        low_cnt++;
        if (first_low < 0) first_low = i;
      end
      if (i == 1) warm = 1'b0;
      if (retrig && i == 6) warm = 1'b1;
      if (retrig && i == 7) warm = 1'b0;
      nwait(1);
    end
  endtask

  initial begin
    int lc;
    int fl;
    nwait(1);
    // R10 reset state
    chk("R10 reset sys_rst_n", sys_rst_n, 1);
    chk("R10 reset shutdown", sd, 0);
    nwait(2);
    rst = 1'b0;
    nwait(6);
    chk("R10 idle after reset sys_rst_n", sys_rst_n, 1);
    chk("R10 idle after reset shutdown", sd, 0);

    // R1 / R2 single pulse
    pulse_run(1'b0, lc, fl);
    chk("R1 pulse first low sample", fl, 3);
    chk("R2 pulse length", lc, P);
    chk("R2 released high", sys_rst_n, 1);

    // R3 retrigger during pulse
    pulse_run(1'b1, lc, fl);
    chk("R3 retrigger length", lc, P);
    chk("R3 released high", sys_rst_n, 1);

    // R4 / R5 / R6 sweep: pending reboot x watchdog level
    for (int pre = 0; pre < 2; pre++) begin
      for (int wd = 0; wd < 2; wd++) begin
        logic exp_sd;
        string tag;
        exp_sd = (wd == 1) && (pre == 0);
        tag = exp_sd ? "R4 qualifying fall" : (pre == 1 ? "R5 pending reboot" : "R6 watchdog low");
        flush();
        clear_flag();
        if (pre == 1) begin
          warm = 1'b1; nwait(1); warm = 1'b0; nwait(P + 6);
        end
        wdog_n = wd[0]; nwait(4);
        shut_n = 1'b0; nwait(2);
        chk("R1 no change at second edge", sd, 0);
        nwait(1);
        chk(tag, sd, exp_sd);
        nwait(3);
        shut_n = 1'b1; wdog_n = 1'b1; nwait(6);
        chk("R8 flag held until clear", sd, exp_sd);
        clear_flag();
        chk("R8 clear drops flag", sd, 0);
      end
    end

    // R7 non-latching edge still consumes the pending reboot
    flush();
    warm = 1'b1; nwait(1); warm = 1'b0; nwait(P + 6);
    shut_n = 1'b0; nwait(4);
    chk("R5 fall after reboot request", sd, 0);
    shut_n = 1'b1; nwait(4);
    shut_n = 1'b0; nwait(4);
    chk("R7 pending reboot consumed", sd, 1);
    shut_n = 1'b1; nwait(4);
    clear_flag();
    chk("R8 clear after R7", sd, 0);

    // R8 set wins over clear in the same cycle
    flush();
    shut_n = 1'b0; nwait(2);
    clr = 1'b1; nwait(1); clr = 1'b0;
    chk("R8 set wins over clear", sd, 1);
    shut_n = 1'b1; nwait(4);
    clear_flag();
    chk("R8 clear after set-wins", sd, 0);

    // R9 warm rise and shutdown fall together
    flush();
    warm = 1'b1; shut_n = 1'b0; nwait(1);
    warm = 1'b0; nwait(2);
    chk("R9 same-cycle no shutdown", sd, 0);
    chk("R9 same-cycle pulse started", sys_rst_n, 0);
    nwait(P + 4);
    chk("R9 flag still low", sd, 0);
    chk("R9 pulse released", sys_rst_n, 1);
    shut_n = 1'b1; nwait(4);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog R1-timeout actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule